// File: doc/BRIEF.md
# Loop Branch Predictor

This block spots conditional branches that behave like loop control and predicts their exit exactly. Such a branch goes one way a fixed number of times and then the other way once. A plain two-bit counter always mispredicts that single exit. Here the block counts iterations and, once it has seen the same trip count often enough, predicts the turn at the right iteration.

A small direct-mapped table is indexed by the low bits of the branch address and tagged with the rest. Each entry holds:
- the dominant direction,
- the learned trip count,
- the running iteration count,
- a saturating confidence count,
- a flag that marks the branch as not loop-like.

The fetch side presents an address and reads back a hit, a confidence flag and a direction, all combinationally. An outer chooser uses the confidence flag to decide whether to trust this block over its other predictors. The resolve side presents the address and the real outcome of each executed branch. Those updates train the table on the next clock edge.

Top module: `loop_pred`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns lkp_hit=0, lkp_conf=0 and lkp_taken=0.
- R2: The entry index is address bits [IDX_W-1:0] and the tag is bits [ADDR_W-1:IDX_W]. A lookup hits when the indexed entry is valid and its tag matches. On a miss, lkp_taken=0 and lkp_conf=0.
- R3: lkp_conf is 1 only when the lookup hits, the entry's confidence equals its maximum (2^CONF_W-1) and the entry is not marked not-loop-like.
- R4: When lkp_conf=1, lkp_taken is the opposite of the dominant direction if the iteration count equals the trip count, and the dominant direction otherwise. On a hit with lkp_conf=0, lkp_taken is the dominant direction. Taken is encoded as 1.
- R5: An update that misses (invalid entry or tag mismatch) allocates the entry with the new tag, dominant direction equal to the update outcome, zero iteration count, zero trip count, zero confidence, untrained and loop-like.
- R6: On a hit, an outcome equal to the dominant direction increments the iteration count.
- R7: On an untrained hit with a nonzero iteration count, the first outcome opposite to the dominant direction stores the iteration count as the trip count, marks the entry trained, clears the iteration count and leaves confidence at zero.
- R8: On a trained hit, an opposite outcome at an iteration count equal to the trip count increments confidence, saturating at the maximum. At any other count it replaces the trip count and clears confidence. Either way it clears the iteration count.
- R9: On an untrained hit with iteration count zero, an opposite outcome makes that outcome the new dominant direction and leaves the counts at zero.
- R10: A dominant outcome while the iteration count is at its maximum (2^CNT_W-1) marks the entry not-loop-like and clears confidence. Further updates with the same tag leave that entry unchanged until it is reallocated.
- R11: A lookup returns the table state before any update in the same cycle. An update is visible to lookups from the next cycle on.
- R12: An update changes only the entry at its own index. Lookups at other indices are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lkp_addr | input | ADDR_W | Branch address to predict |
| lkp_hit | output | 1 | Indexed entry is valid and its tag matches |
| lkp_conf | output | 1 | Entry is confident and loop-like |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The main stimulus is a loop-closing pattern (taken runs ending in one not-taken) and its mirror, a top-tested loop (not-taken runs ending in one taken). Together they show that the dominant direction is learned per entry rather than assumed. A sequence whose trip count changes midway separates the confirm path from the retrain path and shows confidence collapsing. A branch whose first outcome is its rare exit exercises the direction flip. An endless taken run drives the iteration counter into saturation and the not-loop-like state. Interleaved updates and lookups at different indices, plus an aliasing address on a shared index, show that updates stay isolated and that a tag mismatch reallocates the entry.

// File: rtl/lp_pkg.sv
package lp_pkg;

  // Update action chosen for the indexed entry
  typedef enum logic [2:0] {
    ACT_ALLOC   = 3'd0,
    ACT_HOLD    = 3'd1,
    ACT_COUNT   = 3'd2,
    ACT_SATURATE= 3'd3,
    ACT_TRAIN   = 3'd4,
    ACT_CONFIRM = 3'd5,
    ACT_RETRAIN = 3'd6,
    ACT_FLIP    = 3'd7
  } lp_act_e;

endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/lp_addr_split.sv
module lp_addr_split #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  assign idx = addr[IDX_W-1:0];
  assign tag = addr[ADDR_W-1:IDX_W];
endmodule

// File: rtl/lp_entry.sv
module lp_entry #(
  parameter int TAG_W  = 12,
  parameter int CNT_W  = 6,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              valid_d,
  input  logic [TAG_W-1:0]  tag_d,
  input  logic              dir_d,
  input  logic [CNT_W-1:0]  trip_d,
  input  logic [CNT_W-1:0]  iter_d,
  input  logic [CONF_W-1:0] conf_d,
  input  logic              dead_d,
  input  logic              trained_d,
  output logic              valid_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic              dir_q,
  output logic [CNT_W-1:0]  trip_q,
  output logic [CNT_W-1:0]  iter_q,
  output logic [CONF_W-1:0] conf_q,
  output logic              dead_q,
  output logic              trained_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      tag_q     <= '0;
      dir_q     <= 1'b0;
      trip_q    <= '0;
      iter_q    <= '0;
      conf_q    <= '0;
      dead_q    <= 1'b0;
      trained_q <= 1'b0;
    end else if (wr_en) begin
      valid_q   <= valid_d;
      tag_q     <= tag_d;
      dir_q     <= dir_d;
      trip_q    <= trip_d;
      iter_q    <= iter_d;
      conf_q    <= conf_d;
      dead_q    <= dead_d;
      trained_q <= trained_d;
    end
  end
endmodule

// File: rtl/lp_update_ctrl.sv
module lp_update_ctrl
  import lp_pkg::*;
#(
  parameter int TAG_W  = 12,
  parameter int CNT_W  = 6,
  parameter int CONF_W = 2
) (
  input  logic              upd_taken,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic              valid_q,
  input  logic [TAG_W-1:0]  tag_q,
  input  logic              dir_q,
  input  logic [CNT_W-1:0]  trip_q,
  input  logic [CNT_W-1:0]  iter_q,
  input  logic [CONF_W-1:0] conf_q,
  input  logic              dead_q,
  input  logic              trained_q,
  output lp_act_e           act,
  output logic              valid_d,
  output logic [TAG_W-1:0]  tag_d,
  output logic              dir_d,
  output logic [CNT_W-1:0]  trip_d,
  output logic [CNT_W-1:0]  iter_d,
  output logic [CONF_W-1:0] conf_d,
  output logic              dead_d,
  output logic              trained_d
);
  localparam logic [CNT_W-1:0]  ITER_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic tag_match;
  assign tag_match = valid_q && (tag_q == upd_tag);

  // Action select
  always_comb begin
    if (!tag_match)                    act = ACT_ALLOC;
    else if (dead_q)                   act = ACT_HOLD;
    else if (upd_taken == dir_q)       act = (iter_q == ITER_MAX) ? ACT_SATURATE : ACT_COUNT;
    else if (!trained_q)               act = (iter_q == '0) ? ACT_FLIP : ACT_TRAIN;
    else if (iter_q == trip_q)         act = ACT_CONFIRM;
    else                               act = ACT_RETRAIN;
  end

  // Next entry contents
  always_comb begin
    valid_d   = valid_q;
    tag_d     = tag_q;
    dir_d     = dir_q;
    trip_d    = trip_q;
    iter_d    = iter_q;
    conf_d    = conf_q;
    dead_d    = dead_q;
    trained_d = trained_q;
    unique case (act)
      ACT_ALLOC: begin
        valid_d   = 1'b1;
        tag_d     = upd_tag;
        dir_d     = upd_taken;
        trip_d    = '0;
        iter_d    = '0;
        conf_d    = '0;
        dead_d    = 1'b0;
        trained_d = 1'b0;
      end
      ACT_HOLD: ;
      ACT_COUNT:    iter_d = iter_q + 1'b1;
      ACT_SATURATE: begin
        dead_d = 1'b1;
        conf_d = '0;
      end
      ACT_FLIP:     dir_d = upd_taken;
      ACT_TRAIN: begin
        trip_d    = iter_q;
        trained_d = 1'b1;
        iter_d    = '0;
        conf_d    = '0;
      end
      ACT_CONFIRM: begin
        iter_d = '0;
        if (conf_q != CONF_MAX) conf_d = conf_q + 1'b1;
      end
      ACT_RETRAIN: begin
        trip_d = iter_q;
        iter_d = '0;
        conf_d = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lp_predict.sv
module lp_predict #(
  parameter int TAG_W  = 12,
  parameter int CNT_W  = 6,
  parameter int CONF_W = 2
) (
  input  logic [TAG_W-1:0]  lkp_tag,
  input  logic              valid_q,
  input  logic [TAG_W-1:0]  tag_q,
  input  logic              dir_q,
  input  logic [CNT_W-1:0]  trip_q,
  input  logic [CNT_W-1:0]  iter_q,
  input  logic [CONF_W-1:0] conf_q,
  input  logic              dead_q,
  output logic              hit,
  output logic              conf_ok,
  output logic              taken,
  output logic              pred_exit
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  always_comb begin
    hit       = valid_q && (tag_q == lkp_tag);
    conf_ok   = hit && !dead_q && (conf_q == CONF_MAX);
    pred_exit = conf_ok && (iter_q == trip_q);
    if (!hit)          taken = 1'b0;
    else if (pred_exit) taken = !dir_q;
    else               taken = dir_q;
  end
endmodule

// File: rtl/loop_pred.sv
module loop_pred
  import lp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 6,
  parameter int CONF_W = 2,
  localparam int TAG_W   = ADDR_W - IDX_W,
  localparam int NUM_ENT = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_hit,
  output logic              lkp_conf,
  output logic              lkp_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken
);
  logic rst_sync_n;

  lp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  logic [IDX_W-1:0] lkp_idx, upd_idx;
  logic [TAG_W-1:0] lkp_tag, upd_tag;

  lp_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lkp_split (
    .addr(lkp_addr), .idx(lkp_idx), .tag(lkp_tag));
  lp_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_split (
    .addr(upd_addr), .idx(upd_idx), .tag(upd_tag));

  // Table storage
  logic              ent_valid   [NUM_ENT];
  logic [TAG_W-1:0]  ent_tag     [NUM_ENT];
  logic              ent_dir     [NUM_ENT];
  logic [CNT_W-1:0]  ent_trip    [NUM_ENT];
  logic [CNT_W-1:0]  ent_iter    [NUM_ENT];
  logic [CONF_W-1:0] ent_conf    [NUM_ENT];
  logic              ent_dead    [NUM_ENT];
  logic              ent_trained [NUM_ENT];

  // Shared next-state for the entry addressed by the update port
  lp_act_e           upd_act;
  logic              nx_valid, nx_dir, nx_dead, nx_trained;
  logic [TAG_W-1:0]  nx_tag;
  logic [CNT_W-1:0]  nx_trip, nx_iter;
  logic [CONF_W-1:0] nx_conf;

  lp_update_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W), .CONF_W(CONF_W)) u_upd (
    .upd_taken (upd_taken),
    .upd_tag   (upd_tag),
    .valid_q   (ent_valid[upd_idx]),
    .tag_q     (ent_tag[upd_idx]),
    .dir_q     (ent_dir[upd_idx]),
    .trip_q    (ent_trip[upd_idx]),
    .iter_q    (ent_iter[upd_idx]),
    .conf_q    (ent_conf[upd_idx]),
    .dead_q    (ent_dead[upd_idx]),
    .trained_q (ent_trained[upd_idx]),
    .act       (upd_act),
    .valid_d   (nx_valid),
    .tag_d     (nx_tag),
    .dir_d     (nx_dir),
    .trip_d    (nx_trip),
    .iter_d    (nx_iter),
    .conf_d    (nx_conf),
    .dead_d    (nx_dead),
    .trained_d (nx_trained)
  );

  // A hold leaves the entry untouched, so its write enable is gated off
  logic upd_write;
  assign upd_write = upd_valid && (upd_act != ACT_HOLD);

  for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
    logic wr_en;
    assign wr_en = upd_write && (upd_idx == IDX_W'(gi));

    lp_entry #(.TAG_W(TAG_W), .CNT_W(CNT_W), .CONF_W(CONF_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_en     (wr_en),
      .valid_d   (nx_valid),
      .tag_d     (nx_tag),
      .dir_d     (nx_dir),
      .trip_d    (nx_trip),
      .iter_d    (nx_iter),
      .conf_d    (nx_conf),
      .dead_d    (nx_dead),
      .trained_d (nx_trained),
      .valid_q   (ent_valid[gi]),
      .tag_q     (ent_tag[gi]),
      .dir_q     (ent_dir[gi]),
      .trip_q    (ent_trip[gi]),
      .iter_q    (ent_iter[gi]),
      .conf_q    (ent_conf[gi]),
      .dead_q    (ent_dead[gi]),
      .trained_q (ent_trained[gi])
    );
  end

  logic pred_exit;

  lp_predict #(.TAG_W(TAG_W), .CNT_W(CNT_W), .CONF_W(CONF_W)) u_pred (
    .lkp_tag   (lkp_tag),
    .valid_q   (ent_valid[lkp_idx]),
    .tag_q     (ent_tag[lkp_idx]),
    .dir_q     (ent_dir[lkp_idx]),
    .trip_q    (ent_trip[lkp_idx]),
    .iter_q    (ent_iter[lkp_idx]),
    .conf_q    (ent_conf[lkp_idx]),
    .dead_q    (ent_dead[lkp_idx]),
    .hit       (lkp_hit),
    .conf_ok   (lkp_conf),
    .taken     (lkp_taken),
    .pred_exit (pred_exit)
  );
endmodule

// File: rtl/loop_pred_chk.sv
module loop_pred_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] lkp_addr,
  input logic              lkp_hit,
  input logic              lkp_conf,
  input logic              lkp_taken,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              upd_taken,
  input logic [IDX_W-1:0]  lkp_idx,
  input logic [IDX_W-1:0]  upd_idx,
  input logic              pred_exit
);
  // R3: confidence is only reported on a hit
  a_r3_conf_needs_hit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lkp_conf |-> lkp_hit);

  // R2: a miss predicts not taken, without confidence
  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lkp_hit |-> (!lkp_taken && !lkp_conf));

  // R5: any update makes its own address hit on the next cycle
  a_r5_update_hits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && (lkp_addr == upd_addr)) |=> (!$stable(lkp_addr) || lkp_hit));

  // R8: a confident entry that sees the exit early loses its confidence
  a_r8_early_exit_drops_conf: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lkp_conf && !pred_exit && upd_valid && (upd_addr == lkp_addr) && (upd_taken != lkp_taken))
    |=> (!$stable(lkp_addr) || !lkp_conf));

  // R12: an update at another index leaves the lookup result alone
  a_r12_other_index_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_valid && (upd_idx != lkp_idx))
    |=> (!$stable(lkp_addr) || $stable({lkp_hit, lkp_conf, lkp_taken})));
endmodule

bind loop_pred loop_pred_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .lkp_addr   (lkp_addr),
  .lkp_hit    (lkp_hit),
  .lkp_conf   (lkp_conf),
  .lkp_taken  (lkp_taken),
  .upd_valid  (upd_valid),
  .upd_addr   (upd_addr),
  .upd_taken  (upd_taken),
  .lkp_idx    (lkp_idx),
  .upd_idx    (upd_idx),
  .pred_exit  (pred_exit)
);

// File: tb/loop_pred_tb_top.sv
module loop_pred_tb_top;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int NENT   = 16;
  localparam int ITMAX  = 63;
  localparam int CFMAX  = 3;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] lkp_addr;
  logic              lkp_hit, lkp_conf, lkp_taken;
  logic              upd_valid;
  logic [ADDR_W-1:0] upd_addr;
  logic              upd_taken;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  loop_pred #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_conf(lkp_conf), .lkp_taken(lkp_taken),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference table
  int m_valid[NENT], m_tag[NENT], m_dir[NENT], m_trip[NENT];
  int m_iter[NENT], m_conf[NENT], m_dead[NENT], m_trained[NENT];

  function automatic void model_predict(input logic [ADDR_W-1:0] a,
                                        output bit h, output bit c, output bit t);
    int i;
    i = int'(a[IDX_W-1:0]);
    h = (m_valid[i] != 0) && (m_tag[i] == int'(a[ADDR_W-1:IDX_W]));
    c = h && (m_dead[i] == 0) && (m_conf[i] == CFMAX);
    if (!h) t = 0;
    else if (c && m_iter[i] == m_trip[i]) t = (m_dir[i] == 0);
    else t = (m_dir[i] != 0);
  endfunction

  function automatic void model_update(input logic [ADDR_W-1:0] a, input bit tk);
    int i, tg;
    i  = int'(a[IDX_W-1:0]);
    tg = int'(a[ADDR_W-1:IDX_W]);
    if (m_valid[i] == 0 || m_tag[i] != tg) begin
      m_valid[i] = 1; m_tag[i] = tg; m_dir[i] = tk; m_trip[i] = 0;
      m_iter[i] = 0; m_conf[i] = 0; m_dead[i] = 0; m_trained[i] = 0;
    end else if (m_dead[i] != 0) begin
      // stays as it is
    end else if (int'(tk) == m_dir[i]) begin
      if (m_iter[i] == ITMAX) begin m_dead[i] = 1; m_conf[i] = 0; end
      else m_iter[i]++;
    end else if (m_trained[i] == 0) begin
      if (m_iter[i] == 0) m_dir[i] = tk;
      else begin m_trip[i] = m_iter[i]; m_trained[i] = 1; m_iter[i] = 0; m_conf[i] = 0; end
    end else if (m_iter[i] == m_trip[i]) begin
      if (m_conf[i] < CFMAX) m_conf[i]++;
      m_iter[i] = 0;
    end else begin
      m_trip[i] = m_iter[i]; m_iter[i] = 0; m_conf[i] = 0;
    end
  endfunction

  task automatic check(input string rq, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare against the model before the edge, then advance the model
  task automatic step(input logic [ADDR_W-1:0] la, input bit uv,
                      input logic [ADDR_W-1:0] ua, input bit ut, input string rq);
    bit eh, ec, et;
    @(negedge clk);
    lkp_addr = la; upd_valid = uv; upd_addr = ua; upd_taken = ut;
    #1;
    model_predict(la, eh, ec, et);
    check(rq, "lkp_hit", lkp_hit, eh);
    check(rq, "lkp_conf", lkp_conf, ec);
    check(rq, "lkp_taken", lkp_taken, et);
    if (uv) model_update(ua, ut);
  endtask

  task automatic train(input logic [ADDR_W-1:0] a, input bit tk, input string rq);
    step(a, 1'b1, a, tk, rq);
  endtask

  // Lookup only, with hard expectations worked out from the requirements
  task automatic expect_out(input logic [ADDR_W-1:0] a, input bit h, input bit c,
                            input bit t, input string rq);
    step(a, 1'b0, '0, 1'b0, rq);
    check(rq, "lkp_hit(direct)", lkp_hit, h);
    check(rq, "lkp_conf(direct)", lkp_conf, c);
    check(rq, "lkp_taken(direct)", lkp_taken, t);
  endtask

  localparam logic [ADDR_W-1:0] A_ADR = 16'h0013;  // index 3, tag 1
  localparam logic [ADDR_W-1:0] E_ADR = 16'h0023;  // index 3, tag 2 (alias of A)
  localparam logic [ADDR_W-1:0] B_ADR = 16'h0015;
  localparam logic [ADDR_W-1:0] C_ADR = 16'h0017;
  localparam logic [ADDR_W-1:0] D_ADR = 16'h0019;
  localparam logic [ADDR_W-1:0] F_ADR = 16'h001B;

  initial begin
    for (int i = 0; i < NENT; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_dir[i] = 0; m_trip[i] = 0;
      m_iter[i] = 0; m_conf[i] = 0; m_dead[i] = 0; m_trained[i] = 0;
    end
    rst_n = 1'b0; lkp_addr = '0; upd_valid = 1'b0; upd_addr = '0; upd_taken = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: empty table after reset
    expect_out(A_ADR, 0, 0, 0, "R1");
    expect_out(16'hFFFF, 0, 0, 0, "R1");

    // R6 R7 R8 R4: loop-closing branch, four taken then one not taken
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 4; k++) train(A_ADR, 1'b1, "R6");
      train(A_ADR, 1'b0, "R8");
    end
    train(A_ADR, 1'b1, "R6");
    train(A_ADR, 1'b1, "R6");
    expect_out(A_ADR, 1, 1, 1, "R4");  // mid-loop: dominant
    train(A_ADR, 1'b1, "R6");
    train(A_ADR, 1'b1, "R6");
    expect_out(A_ADR, 1, 1, 0, "R4");  // at trip count: predict exit
    // R11: same-cycle lookup sees pre-update state (exit still predicted)
    step(A_ADR, 1'b1, A_ADR, 1'b0, "R11");
    check("R11", "lkp_taken(direct)", lkp_taken, 1'b0);
    expect_out(A_ADR, 1, 1, 1, "R11"); // next cycle: counter cleared

    // R12: updates at B do not disturb lookups of A
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 3; k++) step(A_ADR, 1'b1, B_ADR, 1'b0, "R12");
      step(A_ADR, 1'b1, B_ADR, 1'b1, "R12");
    end
    // Top-tested loop at B: dominant direction is not taken
    expect_out(B_ADR, 1, 1, 0, "R4");
    for (int k = 0; k < 3; k++) train(B_ADR, 1'b0, "R6");
    expect_out(B_ADR, 1, 1, 1, "R4");

    // R8: trip count changes, confidence collapses then rebuilds
    begin
      int trips[8] = '{3, 3, 3, 3, 3, 5, 5, 5};
      for (int r = 0; r < 8; r++) begin
        for (int k = 0; k < trips[r]; k++) train(C_ADR, 1'b1, "R8");
        train(C_ADR, 1'b0, "R8");
      end
      expect_out(C_ADR, 1, 0, 1, "R8");
    end

    // R9: first outcome seen is the rare exit
    train(D_ADR, 1'b0, "R5");
    expect_out(D_ADR, 1, 0, 0, "R5");
    train(D_ADR, 1'b1, "R9");
    expect_out(D_ADR, 1, 0, 1, "R9");
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 2; k++) train(D_ADR, 1'b1, "R7");
      train(D_ADR, 1'b0, "R7");
    end
    expect_out(D_ADR, 1, 1, 1, "R9");

    // R5 R2: alias on index 3 reallocates, A then misses
    train(E_ADR, 1'b0, "R5");
    expect_out(E_ADR, 1, 0, 0, "R5");
    expect_out(A_ADR, 0, 0, 0, "R2");

    // R10: counter saturation marks the branch not loop-like
    for (int k = 0; k < 65; k++) train(F_ADR, 1'b1, "R10");
    expect_out(F_ADR, 1, 0, 1, "R10");
    for (int r = 0; r < 4; r++) train(F_ADR, 1'b0, "R10");
    expect_out(F_ADR, 1, 0, 1, "R10");
    train(16'h002B, 1'b0, "R10");      // new tag reallocates index 11
    expect_out(16'h002B, 1, 0, 0, "R10");
    expect_out(F_ADR, 0, 0, 0, "R10");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule